// File: doc/BRIEF.md
# Flash Operation Timer and Polling Status Generator

This block keeps time for a parallel NOR flash's program and erase operations and produces the polling status word that a host reads while one of them runs. A command sequencer in front of it decodes the host's write cycles. It sends one-cycle pulses to this block: start a program, start a chip erase, add a sector to a pending sector erase, suspend, resume, or "some other write". The block owns the set of sectors marked for erase and the erase timing. It tells the read path whether a host read returns the status byte or array data, and it raises a one-cycle done pulse when an operation finishes.

Time runs in ticks, and a prescaler divides the clock down to them. A sector erase opens with a short accumulation window. Each new sector command re-opens the window, and the erase itself lasts a fixed number of milliseconds per marked sector. A sector erase can be suspended, which freezes the remaining time, and later resumed. A chip erase runs for a fixed time and cannot be interrupted. Every duration is a parameter, so a bench can shrink them.

Top module: `flash_op_timer`

## Requirements
- R1: After reset the block is idle: `busy_o`=0, `done_o`=0, `status_sel_o`=0 and `status_o`=8'h00.
- R2: An accepted `prog_start` (idle only) keeps `busy_o` high for PROG_TICKS*TICK_DIV clock edges. `done_o` is then high for exactly one cycle, with `busy_o` already low. During the program, status bit 7 reads as the inverse of `prog_bit7`.
- R3: Status bit 6 inverts after every status read (`rd_strobe`) while a program or any erase is running. Status bit 2 inverts after every status read during an erase and keeps its value through the reads of a program.
- R4: `sect_add` in idle or during the window marks sector `sect_idx` and restarts a window of WINDOW_TICKS ticks. Marking an already marked sector restarts the window but does not raise the sector count. Status bit 3 reads 0 during the window.
- R5: When the window runs out, status bit 3 reads 1. The erase then lasts (count of marked sectors) * MS_TICKS * 2^SECT_EXP ticks before `done_o`.
- R6: `chip_start` in idle runs an erase of MS_TICKS * 2^CHIP_EXP ticks with status bit 3 at 1. `sect_add`, `other_wr` and `susp_req` have no effect on it.
- R7: `other_wr` during the window aborts the erase. `busy_o` drops at once, no `done_o` is given, and the marked sectors are forgotten.
- R8: `sect_add` and `other_wr` during the timed erase phase of a sector erase leave its end time unchanged.
- R9: `susp_req` during the erase phase freezes the remaining time. `resume_req` continues from it, so completion comes later by exactly the number of suspended edges.
- R10: `susp_req` during the window sets the remaining time to the full erase time for the marked sectors. That full time is counted from the resume edge.
- R11: While suspended, `busy_o`=0. A read of a marked sector gives `status_sel_o`=1 and inverts bit 2 but not bit 6. A read of an unmarked sector gives `status_sel_o`=0 and changes neither bit.
- R12: On completion the marked set and the count are cleared. A following erase is timed from its own sectors only. In idle, `susp_req` and `resume_req` do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_start | input | 1 | Pulse: start a program operation |
| prog_bit7 | input | 1 | Bit 7 of the data being programmed |
| chip_start | input | 1 | Pulse: start a whole-array erase |
| sect_add | input | 1 | Pulse: mark a sector for erase and (re)open the window |
| sect_idx | input | SECT_W | Sector index for `sect_add` |
| other_wr | input | 1 | Pulse: any host write that is neither sector-add nor suspend |
| susp_req | input | 1 | Pulse: suspend a sector erase |
| resume_req | input | 1 | Pulse: resume a suspended sector erase |
| rd_strobe | input | 1 | One cycle per host read |
| rd_sect | input | SECT_W | Sector addressed by the host read |
| status_o | output | 8 | Polling status byte: bit 7 data polarity, bit 6 toggle, bit 3 erase started, bit 2 erase toggle, others 0 |
| status_sel_o | output | 1 | Current read returns `status_o` rather than array data |
| busy_o | output | 1 | A program or erase is being timed |
| done_o | output | 1 | One-cycle pulse when an operation completes |

## Verification
The bench measures the edge at which each completion happens and compares it with a count computed from the parameters. That catches an erase time that ignores the sector count, a re-added sector that is counted twice, and a window that is not restarted. Suspend is timed across the frozen interval. A design that kept counting, or that reloaded the full time on resume, would finish early or late. After an aborted window, the next erase must be timed from a single sector, which exposes a marked set that was not cleared. Pairs of status reads expose toggle bits that move when they should stay put: bit 2 during a program, and bit 6 or reads of unmarked sectors while suspended.

// File: rtl/flash_op_pkg.sv
// Shared types for the flash operation timer.
// Assumes: one operation at a time; states are encoded in three bits.
package flash_op_pkg;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_WINDOW = 3'd2,
        OP_ERASE  = 3'd3,
        OP_CHIP   = 3'd4,
        OP_SUSP   = 3'd5
    } op_state_e;

    // True in every state where the timer advances.
    function automatic logic is_timed(op_state_e s);
        return (s == OP_PROG) || (s == OP_WINDOW) || (s == OP_ERASE) || (s == OP_CHIP);
    endfunction

    // True in every erase state where status reads invert the erase toggle bit.
    function automatic logic is_erasing(op_state_e s);
        return (s == OP_WINDOW) || (s == OP_ERASE) || (s == OP_CHIP);
    endfunction

endpackage

// File: rtl/fop_prescaler.sv
// Tick prescaler: emits one tick every DIV enabled cycles.
// Assumes: clr_i restarts the phase so that a fresh timer load gets whole ticks;
// the count holds while run_i is low, so a frozen timer keeps its phase.
module fop_prescaler #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    // Phase counter: restart on clear, advance only while the timer runs.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            phase_q <= '0;
        end else if (run_i) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    assign tick_o = run_i && (phase_q == LAST);

    generate
        if (DIV > 1) begin : g_gap
            // Ticks are never adjacent when the divider exceeds one.
            assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/fop_countdown.sv
// Tick-driven countdown: loads a tick count and flags the tick that ends it.
// Assumes: load has priority over a tick in the same cycle; load values are at least 1.
module fop_countdown #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             expire_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    // Remaining ticks: reload on request, otherwise count down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = tick_i && (cnt_q == CNT_W'(1));
    assign cnt_o    = cnt_q;

    // The final tick leaves the counter empty unless a new load replaces it.
    assert_expire_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !load_i) |=> (cnt_q == '0));

endmodule

// File: rtl/fop_status_gen.sv
// Polling status generator: builds the status byte and the status/array select.
// Assumes: the state input is the controller's registered state; a read toggles
// bits after the cycle in which the host sampled the byte.
module fop_status_gen
    import flash_op_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  op_state_e state_i,
    input  logic      rd_strobe_i,
    input  logic      rd_hit_i,
    input  logic      prog_go_i,
    input  logic      prog_bit7_i,
    input  logic      erase_go_i,
    output logic [7:0] status_o,
    output logic      status_sel_o
);
    logic pol_q;
    logic tgl_q;
    logic ers_tgl_q;
    logic gate;
    logic susp_hit;

    assign susp_hit = (state_i == OP_SUSP) && rd_hit_i;
    assign gate     = (state_i == OP_ERASE) || (state_i == OP_CHIP) || (state_i == OP_SUSP);

    // Data polarity bit: inverse of programmed bit 7, low for erases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= 1'b0;
        end else if (prog_go_i) begin
            pol_q <= ~prog_bit7_i;
        end else if (erase_go_i) begin
            pol_q <= 1'b0;
        end
    end

    // Toggle bits: invert on status reads in the states that allow it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl_q     <= 1'b0;
            ers_tgl_q <= 1'b0;
        end else if (rd_strobe_i) begin
            if (is_timed(state_i)) tgl_q <= ~tgl_q;
            if (is_erasing(state_i) || susp_hit) ers_tgl_q <= ~ers_tgl_q;
        end
    end

    assign status_o     = {pol_q, tgl_q, 2'b00, gate, ers_tgl_q, 2'b00};
    assign status_sel_o = is_timed(state_i) || susp_hit;

    // A program never moves the erase toggle bit.
    assert_prog_keeps_ers_tgl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == OP_PROG) |=> $stable(ers_tgl_q));

    // While suspended the main toggle bit holds.
    assert_susp_holds_tgl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == OP_SUSP) |=> $stable(tgl_q));

endmodule

// File: rtl/flash_op_timer.sv
// Flash operation timer: sequences program, chip erase and windowed sector erase
// with suspend/resume, keeps the marked-sector set, and drives the polling status.
// Assumes: command pulses are one cycle wide and already decoded; a tick is
// TICK_DIV clocks; the remaining erase time of a suspend is held in the timer itself.
module flash_op_timer
    import flash_op_pkg::*;
#(
    parameter int NUM_SECTORS  = 8,
    parameter int TICK_DIV     = 100,
    parameter int WINDOW_TICKS = 50,
    parameter int MS_TICKS     = 1000,
    parameter int SECT_EXP     = 9,
    parameter int CHIP_EXP     = 12,
    parameter int PROG_TICKS   = 10,
    localparam int SECT_W      = $clog2(NUM_SECTORS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_start,
    input  logic              prog_bit7,
    input  logic              chip_start,
    input  logic              sect_add,
    input  logic [SECT_W-1:0] sect_idx,
    input  logic              other_wr,
    input  logic              susp_req,
    input  logic              resume_req,
    input  logic              rd_strobe,
    input  logic [SECT_W-1:0] rd_sect,
    output logic [7:0]        status_o,
    output logic              status_sel_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int SECT_UNIT  = MS_TICKS * (2 ** SECT_EXP);
    localparam int CHIP_TICKS = MS_TICKS * (2 ** CHIP_EXP);
    localparam int MAX_SECT   = SECT_UNIT * NUM_SECTORS;
    localparam int MAX_A      = (MAX_SECT > CHIP_TICKS) ? MAX_SECT : CHIP_TICKS;
    localparam int MAX_B      = (WINDOW_TICKS > PROG_TICKS) ? WINDOW_TICKS : PROG_TICKS;
    localparam int MAX_T      = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W      = $clog2(MAX_T + 1);
    localparam int NSECT_W    = $clog2(NUM_SECTORS + 1);

    op_state_e          state_q, state_d;
    logic [NUM_SECTORS-1:0] map_q;
    logic [NSECT_W-1:0] nsect_q;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic [CNT_W-1:0]   tmr_cnt;
    logic [CNT_W-1:0]   erase_total;
    logic               tick;
    logic               expire;
    logic               mark, wipe, done_d, done_q, prog_go, erase_go;

    assign erase_total = CNT_W'(nsect_q) * CNT_W'(SECT_UNIT);

    fop_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (is_timed(state_q)),
        .clr_i (tmr_load),
        .tick_o(tick)
    );

    fop_countdown #(.CNT_W(CNT_W)) u_cdown (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .tick_i    (tick),
        .expire_o  (expire),
        .cnt_o     (tmr_cnt)
    );

    fop_status_gen u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state_q),
        .rd_strobe_i (rd_strobe),
        .rd_hit_i    (map_q[rd_sect]),
        .prog_go_i   (prog_go),
        .prog_bit7_i (prog_bit7),
        .erase_go_i  (erase_go),
        .status_o    (status_o),
        .status_sel_o(status_sel_o)
    );

    // Next state, timer loads and set maintenance for each command pulse.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        mark     = 1'b0;
        wipe     = 1'b0;
        done_d   = 1'b0;
        prog_go  = 1'b0;
        erase_go = 1'b0;
        unique case (state_q)
            OP_IDLE: begin
                if (prog_start) begin
                    state_d = OP_PROG; tmr_load = 1'b1; tmr_val = CNT_W'(PROG_TICKS);
                    prog_go = 1'b1;
                end else if (chip_start) begin
                    state_d = OP_CHIP; tmr_load = 1'b1; tmr_val = CNT_W'(CHIP_TICKS);
                    erase_go = 1'b1;
                end else if (sect_add) begin
                    state_d = OP_WINDOW; tmr_load = 1'b1; tmr_val = CNT_W'(WINDOW_TICKS);
                    mark = 1'b1; erase_go = 1'b1;
                end
            end
            OP_PROG, OP_CHIP: begin
                if (expire) begin
                    state_d = OP_IDLE; done_d = 1'b1;
                end
            end
            OP_WINDOW: begin
                if (sect_add) begin
                    tmr_load = 1'b1; tmr_val = CNT_W'(WINDOW_TICKS); mark = 1'b1;
                end else if (susp_req) begin
                    state_d = OP_SUSP; tmr_load = 1'b1; tmr_val = erase_total;
                end else if (other_wr) begin
                    state_d = OP_IDLE; wipe = 1'b1;
                end else if (expire) begin
                    state_d = OP_ERASE; tmr_load = 1'b1; tmr_val = erase_total;
                end
            end
            OP_ERASE: begin
                if (expire) begin
                    state_d = OP_IDLE; done_d = 1'b1; wipe = 1'b1;
                end else if (susp_req) begin
                    state_d = OP_SUSP;
                end
            end
            OP_SUSP: begin
                if (resume_req) state_d = OP_ERASE;
            end
            default: state_d = OP_IDLE;
        endcase
    end

    // Controller state and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OP_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    // Marked-sector set and its population count.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            map_q   <= '0;
            nsect_q <= '0;
        end else if (mark && !map_q[sect_idx]) begin
            map_q[sect_idx] <= 1'b1;
            nsect_q         <= nsect_q + 1'b1;
        end
    end

    assign busy_o = is_timed(state_q);
    assign done_o = done_q;

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_window_gate_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OP_WINDOW) |-> !status_o[3]);

    assert_chip_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OP_CHIP && !expire) |=> (state_q == OP_CHIP));

    assert_susp_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OP_SUSP && !resume_req) |=> $stable(tmr_cnt));

    assert_busy_reads_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> status_sel_o);

endmodule

// File: tb/flash_op_timer_bench.sv
// Bench for flash_op_timer: directed corners plus seeded random erase/program runs,
// completion edges checked against durations computed from the parameters.
module flash_op_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS   = 8;
    localparam int DIV  = 3;
    localparam int WIN  = 4;
    localparam int MS   = 2;
    localparam int SE   = 2;
    localparam int CE   = 3;
    localparam int PT   = 5;
    localparam int SU   = MS * (2 ** SE);
    localparam int CHT  = MS * (2 ** CE);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_start = 1'b0, prog_bit7 = 1'b0, chip_start = 1'b0, sect_add = 1'b0;
    logic [2:0] sect_idx = '0, rd_sect = '0;
    logic other_wr = 1'b0, susp_req = 1'b0, resume_req = 1'b0, rd_strobe = 1'b0;
    logic [7:0] status_o;
    logic status_sel_o, busy_o, done_o;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    int last_edge = 0;
    bit finished = 0;

    flash_op_timer #(
        .NUM_SECTORS(NS), .TICK_DIV(DIV), .WINDOW_TICKS(WIN), .MS_TICKS(MS),
        .SECT_EXP(SE), .CHIP_EXP(CE), .PROG_TICKS(PT)
    ) u_flash_op_timer (
        .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .prog_bit7(prog_bit7),
        .chip_start(chip_start), .sect_add(sect_add), .sect_idx(sect_idx),
        .other_wr(other_wr), .susp_req(susp_req), .resume_req(resume_req),
        .rd_strobe(rd_strobe), .rd_sect(rd_sect), .status_o(status_o),
        .status_sel_o(status_sel_o), .busy_o(busy_o), .done_o(done_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic int prog_cycles();
        return PT * DIV;
    endfunction

    function automatic int erase_cycles(int n);
        return (WIN + n * SU) * DIV;
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_prog(input logic b);
        prog_start = 1'b1; prog_bit7 = b;
        @(negedge clk); prog_start = 1'b0; last_edge = cyc;
    endtask

    task automatic do_chip();
        chip_start = 1'b1;
        @(negedge clk); chip_start = 1'b0; last_edge = cyc;
    endtask

    task automatic do_add(input int idx);
        sect_add = 1'b1; sect_idx = idx[2:0];
        @(negedge clk); sect_add = 1'b0; last_edge = cyc;
    endtask

    task automatic do_other();
        other_wr = 1'b1;
        @(negedge clk); other_wr = 1'b0; last_edge = cyc;
    endtask

    task automatic do_susp();
        susp_req = 1'b1;
        @(negedge clk); susp_req = 1'b0; last_edge = cyc;
    endtask

    task automatic do_resume();
        resume_req = 1'b1;
        @(negedge clk); resume_req = 1'b0; last_edge = cyc;
    endtask

    task automatic do_read(input int idx, output logic [7:0] st, output logic sel);
        rd_strobe = 1'b1; rd_sect = idx[2:0];
        #1;
        st = status_o; sel = status_sel_o;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic expect_done(string tag, int exp_edge);
        int e = -1;
        int g = 0;
        while (!done_o && g < 4000) begin
            @(negedge clk); g++;
        end
        if (done_o) e = cyc;
        chk(tag, e, exp_edge);
        chk({tag, " busy low at done"}, busy_o, 0);
        @(negedge clk);
        chk("R2 done is one cycle", done_o, 0);
    endtask

    initial begin
        logic [7:0] a, b;
        logic sa, sb;
        int s, su, rs;
        logic [7:0] bm;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        do_read(0, a, sa);
        chk("R1 status", a, 0);
        chk("R1 select", sa, 0);

        // R2, R3: program with bit7=1
        do_prog(1'b1); s = last_edge;
        do_read(0, a, sa);
        do_read(0, b, sb);
        chk("R2 polarity bit", a[7], 0);
        chk("R2 select during program", sa, 1);
        chk("R3 bit6 toggles in program", b[6], !a[6]);
        chk("R3 bit2 holds in program", b[2], a[2]);
        expect_done("R2 program time", s + prog_cycles());

        // R4, R5: window restart and re-add of a marked sector
        do_add(0);
        do_read(0, a, sa);
        chk("R4 bit3 low in window", a[3], 0);
        do_read(0, b, sb);
        chk("R3 bit2 toggles in window", b[2], !a[2]);
        chk("R3 bit6 toggles in window", b[6], !a[6]);
        do_add(0);
        do_add(5); s = last_edge;
        repeat (WIN * DIV + 2) @(negedge clk);
        do_read(3, a, sa);
        chk("R5 bit3 high in erase", a[3], 1);
        expect_done("R4 R5 two-sector erase time", s + erase_cycles(2));

        // R6: chip erase ignores other pulses
        do_chip(); s = last_edge;
        do_read(0, a, sa);
        chk("R6 bit3 high in chip erase", a[3], 1);
        do_add(3);
        do_other();
        do_susp();
        chk("R6 still busy", busy_o, 1);
        expect_done("R6 chip erase time", s + CHT * DIV);

        // R7: abort in the window
        do_add(1);
        do_add(3);
        do_other();
        chk("R7 busy drops on abort", busy_o, 0);
        begin
            int seen = 0;
            repeat (40) begin
                @(negedge clk);
                if (done_o) seen++;
            end
            chk("R7 no done after abort", seen, 0);
        end
        do_read(1, a, sa);
        chk("R7 idle select", sa, 0);
        do_add(6); s = last_edge;
        expect_done("R7 set forgotten after abort", s + erase_cycles(1));

        // R8: writes during the erase phase are ignored
        do_add(2); s = last_edge;
        repeat (WIN * DIV + 2) @(negedge clk);
        do_other();
        do_add(4);
        expect_done("R8 erase time unchanged", s + erase_cycles(1));

        // R9, R11: suspend during the erase phase
        do_add(2);
        do_add(7); s = last_edge;
        repeat (WIN * DIV + 10) @(negedge clk);
        do_susp(); su = last_edge;
        chk("R11 busy low when suspended", busy_o, 0);
        do_read(7, a, sa);
        do_read(0, b, sb);
        chk("R11 marked sector reads status", sa, 1);
        chk("R11 unmarked sector reads array", sb, 0);
        do_read(2, b, sb);
        chk("R11 bit2 toggles on marked read", b[2], !a[2]);
        chk("R11 bit6 held while suspended", b[6], a[6]);
        repeat (20) @(negedge clk);
        do_resume(); rs = last_edge;
        expect_done("R9 suspended time excluded", s + erase_cycles(2) + (rs - su));

        // R10: suspend inside the window
        do_add(4);
        repeat (2) @(negedge clk);
        do_susp();
        repeat (15) @(negedge clk);
        do_resume(); rs = last_edge;
        expect_done("R10 full time from resume", rs + SU * DIV);

        // R12: set cleared after completion; idle ignores suspend/resume
        do_read(4, a, sa);
        chk("R12 idle select after erase", sa, 0);
        do_susp();
        do_resume();
        chk("R12 idle suspend/resume ignored", busy_o, 0);
        do_add(1); s = last_edge;
        expect_done("R12 only new sector timed", s + erase_cycles(1));

        // Random mix of programs and sector erases
        for (int it = 0; it < 12; it++) begin
            if ($urandom % 3 == 0) begin
                logic bit7;
                bit7 = 1'($urandom % 2);
                do_prog(bit7); s = last_edge;
                do_read(0, a, sa);
                chk("R2 random polarity", a[7], !bit7);
                expect_done("R2 random program time", s + prog_cycles());
            end else begin
                int n;
                bm = '0;
                n = 1 + int'($urandom % 4);
                for (int k = 0; k < n; k++) begin
                    int idx;
                    idx = int'($urandom % NS);
                    do_add(idx);
                    s = last_edge;
                    bm[idx] = 1'b1;
                    repeat (int'($urandom % 3)) @(negedge clk);
                end
                expect_done("R5 random erase time", s + erase_cycles($countones(bm)));
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule